// File: doc/BRIEF.md
# Timer Event Resolver

This block sits between the counters of a state-driven timer and the logic that acts on timer events. The timer has two 16-bit halves, L and H. Each half has its own run flag, its own 5-bit state and its own set of match flags. The block can also treat the two halves as one counter. Each clock, the block evaluates sixteen programmable events.

An event can use a match flag from its counter, a condition on one selected input or output pin, or both, combined as its mode picks. An event fires only when its counter is running and the counter's current state is enabled in the event's state mask. Every fired event is reported in a 16-bit vector. For each counter, the block works out the next state from the fired events and raises a load strobe when that state is to be applied.

The results are combinational from the current inputs. The only storage is one register per selectable pin, which holds that pin's value from the previous clock so that edges can be detected. The counters, the match comparators and the pin drivers are outside this block.

Top module: `timer_event_unit`

## Requirements
- R1: Bit 4 of an event's 14-bit control word picks its counter: 0 selects L (L state, L run flag, `match_l`) and 1 selects H. While `unify` is 1, bit 4 is ignored and every event uses L.
- R2: Bits 9:6 pick a pin index. Bit 5 picks the source: 0 reads `pin_out[index]` and 1 reads `pin_in[index]`.
- R3: Bits 11:10 pick the pin condition: 0 = low, 1 = rising edge, 2 = falling edge, 3 = high. An edge compares the pin with its value at the previous clock edge, and that stored value is 0 after reset.
- R4: Bits 13:12 pick the combine mode: 0 = match OR pin condition, 1 = match only, 2 = pin condition only, 3 = match AND pin condition. The match flag used is bit [3:0] of the counter's match vector.
- R5: An event whose counter's run flag is 0 does not fire.
- R6: An event fires only if bit [current state of its counter] of its 32-bit state mask is 1. An event whose mask is all zero never fires.
- R7: A counter's next state is the `ev_next` value of the highest-numbered fired event for that counter whose `ev_load` bit is 1. Lower-numbered events that fire in the same cycle still set their bits in `ev_fired`.
- R8: A counter's load strobe is 1 exactly when at least one fired event for that counter has its `ev_load` bit set. When the strobe is 0, the next-state output equals the current state.
- R9: While `unify` is 1, `load_h` stays 0 and `next_h` equals `state_h`.
- R10: While `rst_n` is 0, `ev_fired` is all zero and both load strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| unify | input | 1 | Treat both halves as one counter |
| ev_ctrl | input | 224 | Control words, 14 bits per event, event e at [14e+13:14e] |
| ev_mask | input | 512 | State masks, 32 bits per event |
| ev_next | input | 80 | Next-state values, 5 bits per event |
| ev_load | input | 16 | Load enable per event |
| match_l | input | 16 | Match flags of the L half |
| match_h | input | 16 | Match flags of the H half |
| pin_in | input | 16 | Synchronized input pins |
| pin_out | input | 16 | Current output pins |
| run_l | input | 1 | L counter running |
| run_h | input | 1 | H counter running |
| state_l | input | 5 | Current L state |
| state_h | input | 5 | Current H state |
| ev_fired | output | 16 | Events fired this cycle |
| next_l | output | 5 | Next L state |
| load_l | output | 1 | Apply next_l |
| next_h | output | 5 | Next H state |
| load_h | output | 1 | Apply next_h |

## Verification
The assertions assume that the pins and the match flags are stable around the sampling edge and that `unify`, the control words and the masks come from ordinary registers, so that no input is X after reset. The stimulus changes every input only at the falling clock edge and sets each input to a defined value from time zero.

Several phases of the stimulus bias the random values toward one corner each: counters halted, empty masks, unified mode, masks full with all matches set so that many events collide, and load enables withheld. Each of these corners is therefore exercised many times under random control words.

// File: rtl/timer_event_unit.sv
module timer_event_unit #(
  parameter int NEV = 16,
  parameter int SW  = 5,
  parameter int NIO = 16,
  parameter int NMT = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   unify,
  input  logic [NEV*14-1:0]      ev_ctrl,
  input  logic [NEV*(1<<SW)-1:0] ev_mask,
  input  logic [NEV*SW-1:0]      ev_next,
  input  logic [NEV-1:0]         ev_load,
  input  logic [NMT-1:0]         match_l,
  input  logic [NMT-1:0]         match_h,
  input  logic [NIO-1:0]         pin_in,
  input  logic [NIO-1:0]         pin_out,
  input  logic                   run_l,
  input  logic                   run_h,
  input  logic [SW-1:0]          state_l,
  input  logic [SW-1:0]          state_h,
  output logic [NEV-1:0]         ev_fired,
  output logic [SW-1:0]          next_l,
  output logic                   load_l,
  output logic [SW-1:0]          next_h,
  output logic                   load_h
);
  localparam int CW = 14;
  localparam int NS = 1 << SW;

  logic [NIO-1:0] prev_in, prev_out;
  logic [NEV-1:0] use_h;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_in  <= '0;
      prev_out <= '0;
    end else begin
      prev_in  <= pin_in;
      prev_out <= pin_out;
    end

  for (genvar e = 0; e < NEV; e++) begin : g_ev
    wire [CW-1:0] cw   = ev_ctrl[e*CW +: CW];
    wire [NS-1:0] msk  = ev_mask[e*NS +: NS];
    wire          hsel = !unify && cw[4];
    wire [3:0]    isel = cw[9:6];
    wire          cur  = cw[5] ? pin_in[isel]  : pin_out[isel];
    wire          old  = cw[5] ? prev_in[isel] : prev_out[isel];
    wire          mt   = hsel ? match_h[cw[3:0]] : match_l[cw[3:0]];
    wire          run  = hsel ? run_h : run_l;
    wire [SW-1:0] st   = hsel ? state_h : state_l;
    logic         io, hit;
    always_comb begin
      case (cw[11:10])
        2'd0:    io = !cur;
        2'd1:    io = cur && !old;
        2'd2:    io = !cur && old;
        default: io = cur;
      endcase
      case (cw[13:12])
        2'd0:    hit = mt || io;
        2'd1:    hit = mt;
        2'd2:    hit = io;
        default: hit = mt && io;
      endcase
    end
    assign use_h[e]    = hsel;
    assign ev_fired[e] = rst_n && run && msk[st] && hit;

    assert_fire_needs_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_fired[e] |-> (ev_mask[e*NS +: NS] != '0));
  end

  always_comb begin
    next_l = state_l;
    next_h = state_h;
    load_l = 1'b0;
    load_h = 1'b0;
    for (int e = 0; e < NEV; e++) begin
      if (ev_fired[e] && ev_load[e]) begin
        if (use_h[e]) begin
          next_h = ev_next[e*SW +: SW];
          load_h = 1'b1;
        end else begin
          next_l = ev_next[e*SW +: SW];
          load_l = 1'b1;
        end
      end
    end
  end

  assert_halt_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_l && !run_h) |-> (ev_fired == '0));
  assert_hold_l_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_l |-> (next_l == state_l));
  assert_hold_h_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_h |-> (next_h == state_h));
  assert_load_needs_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_l || load_h) |-> (ev_fired != '0));
  assert_unify_h_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unify |-> !load_h);
endmodule

// File: tb/sim_timer_event_unit.sv
module sim_timer_event_unit;
  localparam int PERIOD = 10;
  localparam int NEV = 16;

  logic clk = 0, rst_n = 0, unify = 0;
  logic [NEV*14-1:0] ev_ctrl = '0;
  logic [NEV*32-1:0] ev_mask = '0;
  logic [NEV*5-1:0]  ev_next = '0;
  logic [15:0] ev_load = '0, match_l = '0, match_h = '0, pin_in = '0, pin_out = '0;
  logic run_l = 0, run_h = 0;
  logic [4:0] state_l = '0, state_h = '0;
  logic [15:0] ev_fired;
  logic [4:0] next_l, next_h;
  logic load_l, load_h;

  int checks = 0, fails = 0;
  logic [15:0] p_in = '0, p_out = '0;
  string tag = "R10";
  logic wd_done = 0;

  always #(PERIOD/2) clk = ~clk;

  timer_event_unit u0 (.*);

  always @(posedge clk) begin
    if (!rst_n) begin p_in <= '0; p_out <= '0; end
    else begin p_in <= pin_in; p_out <= pin_out; end
  end

  task automatic chk(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [15:0] f = '0;
    logic [4:0] nl = state_l, nh = state_h;
    logic ll = 0, lh = 0;
    for (int e = 0; e < NEV; e++) begin
      logic [13:0] c = ev_ctrl[e*14 +: 14];
      bit h = !unify && c[4];
      int s = c[9:6];
      bit cur = c[5] ? pin_in[s] : pin_out[s];
      bit old = c[5] ? p_in[s] : p_out[s];
      bit m = h ? match_h[c[3:0]] : match_l[c[3:0]];
      bit io, hit;
      int st = h ? state_h : state_l;
      bit run = h ? run_h : run_l;
      io = (c[11:10] == 0) ? !cur : (c[11:10] == 1) ? (cur & !old) :
           (c[11:10] == 2) ? (!cur & old) : cur;
      hit = (c[13:12] == 0) ? (m | io) : (c[13:12] == 1) ? m :
            (c[13:12] == 2) ? io : (m & io);
      f[e] = rst_n && run && ev_mask[e*32 + st] && hit;
    end
    for (int e = NEV-1; e >= 0; e--)
      if (f[e] && ev_load[e]) begin
        if (!unify && ev_ctrl[e*14+4]) begin
          if (!lh) begin nh = ev_next[e*5 +: 5]; lh = 1; end
        end else if (!ll) begin nl = ev_next[e*5 +: 5]; ll = 1; end
      end
    chk(tag, "ev_fired (R1 R2 R3 R4)", ev_fired, f);
    chk(tag, "next_l R7", next_l, nl);
    chk(tag, "load_l R8", load_l, ll);
    chk(tag, "next_h R7", next_h, nh);
    chk(tag, "load_h R8", load_h, lh);
  endtask

  task automatic drive(input int mode);
    for (int e = 0; e < NEV; e++) begin
      ev_ctrl[e*14 +: 14] = 14'($urandom);
      ev_mask[e*32 +: 32] = $urandom | $urandom;
      ev_next[e*5 +: 5] = 5'($urandom);
    end
    ev_load = 16'($urandom);
    match_l = 16'($urandom); match_h = 16'($urandom);
    pin_in = 16'($urandom); pin_out = 16'($urandom);
    run_l = ($urandom % 4) != 0; run_h = ($urandom % 4) != 0;
    state_l = 5'($urandom); state_h = 5'($urandom);
    unify = ($urandom % 5) == 0;
    case (mode)
      1: begin run_l = 0; run_h = 0; end
      2: ev_mask = '0;
      3: unify = 1;
      4: begin ev_mask = '1; match_l = '1; match_h = '1; run_l = 1; run_h = 1; end
      5: ev_load = '0;
      default: ;
    endcase
  endtask

  initial begin
    #(PERIOD*150000);
    fails++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    wd_done = 1;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); drive(4);
      #(PERIOD/4); tag = "R10"; compare();
    end
    @(negedge clk); rst_n = 1;
    // R3: first cycle after reset sees a rising edge on a high pin
    ev_ctrl = '0; ev_ctrl[13:0] = {2'd2, 2'd1, 4'd3, 1'b1, 1'b0, 4'd0};
    ev_mask = '0; ev_mask[0] = 1; ev_load = 16'h1; ev_next[4:0] = 5'd9;
    pin_in = 16'h0008; run_l = 1; state_l = 0; unify = 0;
    #(PERIOD/4); tag = "R3";
    compare();
    chk("R3", "rise after reset", ev_fired[0], 1);
    @(negedge clk); #(PERIOD/4);
    chk("R3", "no rise on held pin", ev_fired[0], 0);
    for (int ph = 0; ph < 6 && !wd_done; ph++) begin
      case (ph)
        0: tag = "R1 R2 R3 R4";
        1: tag = "R5";
        2: tag = "R6";
        3: tag = "R9";
        4: tag = "R7";
        default: tag = "R8";
      endcase
      for (int i = 0; i < 2000 && !wd_done; i++) begin
        @(negedge clk); drive(ph);
        #(PERIOD/4); compare();
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule